// File: doc/BRIEF.md
# Program Counter and Fetch Sequencer

This block keeps the 12-bit program counter of a small pipelined microcontroller and chooses where each instruction word is fetched from. The system clock is divided into a four-phase instruction cycle. During each instruction cycle the block presents one fetch address. The instruction fetched in the previous cycle executes in parallel, so straight-line code completes one instruction per instruction cycle.

All decisions are taken on the instruction-cycle boundary, which is the rising clock edge that ends the last phase. At that edge the block looks at three kinds of input. The first is the interrupt requests. The second is the decoded control strobes of the executing instruction: skip, low-byte write, jump, call and return. The third is the operands: target field, stack top and low-byte data. From these the block loads the next address. When sequential flow is broken, the word that was already prefetched is marked as a dummy by the `flush` output for one whole instruction cycle. On a call or an interrupt entry, the block emits a push strobe together with the return address for the external stack. On a return it emits a pop strobe.

A three-state machine tracks what occupies the execute slot. `ST_FILL` is the empty slot right after reset. `ST_RUN` is a valid instruction. `ST_DUMMY` is a discarded word. Its transitions are taken at each boundary, and there are three of them. The first is *advance*: no transfer leads to `ST_RUN`. The second is *redirect*: any transfer or interrupt entry leads to `ST_DUMMY`. The third is *reset*: any state returns to `ST_FILL`.

Top module: `pc_sequencer`

## Requirements
- R1: `phase` is one-hot. It steps phase0→phase1→phase2→phase3→phase0, one clock each. Bit i of `phase` marks phase i. `fetch_addr` changes only on the edge that ends phase3.
- R2: While reset is low, and in the first instruction cycle after it, `fetch_addr`=0x000, `exec_pc`=0x000, `phase`=4'b0001, `flush`=1, `push`=0 and `pop`=0.
- R3: With no transfer, `fetch_addr` advances by one per instruction cycle and wraps from 0xFFF to 0x000. `exec_pc` always takes the previous cycle's `fetch_addr`.
- R4: A jump (`do_jump`) loads all 12 bits of `target` into `fetch_addr`. `flush` is then 1 for the following instruction cycle.
- R5: A call (`do_call`) loads `target` like a jump. In the phase0 clock of the next cycle, `push` is 1 for exactly one clock, and `push_addr` equals the fetch address that was current while the call executed.
- R6: A return (`do_ret`) loads `stack_top` into `fetch_addr`. It pulses `pop` for one clock in the next phase0 and sets `flush` for the next cycle.
- R7: A low-byte write (`do_pcl_wr`) sets `fetch_addr` to {current `fetch_addr`[11:8], `pcl_data`}. This stays in the current 256-word page and sets `flush`.
- R8: A true skip (`do_skip`) sets `fetch_addr` to current `fetch_addr`+1, which is the skipping instruction's address +2. It sets `flush`.
- R9: In a cycle where `flush`=1, all instruction strobes are ignored. The next address is sequential and the next cycle has `flush`=0, unless an interrupt is taken.
- R10: At a boundary, `irq_ext` loads 0x004, `irq_tmr0` loads 0x008 and `irq_tmr1` loads 0x00C, with that priority order. Interrupt entry pushes the current `fetch_addr`, sets `flush`, and wins over any instruction transfer.
- R11: Interrupt requests are sampled only at the boundary. A request that rises and falls inside phases 1 to 3 has no effect.
- R12: When several strobes are raised together, precedence is return, then call, then jump, then low-byte write, then skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_ext | input | 1 | External interrupt request |
| irq_tmr0 | input | 1 | Timer 0 overflow request |
| irq_tmr1 | input | 1 | Timer 1 overflow request |
| do_skip | input | 1 | Executing instruction's skip condition is true |
| do_pcl_wr | input | 1 | Executing instruction writes the low PC byte |
| do_jump | input | 1 | Executing instruction is a jump |
| do_call | input | 1 | Executing instruction is a call |
| do_ret | input | 1 | Executing instruction returns (subroutine or interrupt) |
| target | input | 12 | Address field of the executing instruction |
| stack_top | input | 12 | Top entry of the external return stack |
| pcl_data | input | 8 | Byte written to the low PC byte |
| fetch_addr | output | 12 | Address of the word fetched this instruction cycle |
| exec_pc | output | 12 | Address of the word in the execute slot |
| flush | output | 1 | Execute slot holds a dummy word |
| phase | output | 4 | One-hot instruction-cycle phase |
| push | output | 1 | Push strobe for the return stack |
| push_addr | output | 12 | Return address to push |
| pop | output | 1 | Pop strobe for the return stack |

## Verification
The hardest situations to reach from the ports are those where several redirect sources arrive at the same boundary. Examples are an interrupt arriving together with a jump, or a second transfer strobe raised while the slot holds a dummy word. These only matter if they land in exactly the right instruction cycle. The stimulus runs cycle by cycle in step with `phase` and drives every one of the 31 non-empty strobe combinations and all 7 interrupt request combinations at a boundary. Transfers are issued back to back so that the second falls into the flush slot. Interrupt pulses confined to phases 1 to 3 confirm the sampling window, and a jump to 0xFFE exercises the increment wrap.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    // Source of the next fetch address, decided at the cycle boundary.
    typedef enum logic [2:0] {
        XF_NONE,
        XF_SKIP,
        XF_PCL,
        XF_JUMP,
        XF_CALL,
        XF_RET,
        XF_IRQ
    } xfer_e;

    // Occupancy of the execute slot.
    typedef enum logic [1:0] {
        ST_FILL,
        ST_RUN,
        ST_DUMMY
    } slot_e;

    // Decoded control strobes of the executing instruction.
    typedef struct packed {
        logic ret;
        logic call;
        logic jump;
        logic pcl;
        logic skip;
    } strobe_t;

endpackage

// File: rtl/pcseq_phase.sv
module pcseq_phase #(
    parameter int PH_N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_N-1:0] phase,
    output logic            boundary
);
    localparam int PH_W = (PH_N > 1) ? $clog2(PH_N) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(PH_N - 1);

    logic [PH_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign boundary = (cnt == LAST);

    for (genvar i = 0; i < PH_N; i++) begin : g_ph
        assign phase[i] = (cnt == PH_W'(i));
    end

endmodule

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
    import pcseq_pkg::*;
#(
    parameter int              PC_W    = 12,
    parameter int              LOW_W   = 8,
    parameter logic [PC_W-1:0] VEC_EXT = 'h004,
    parameter logic [PC_W-1:0] VEC_T0  = 'h008,
    parameter logic [PC_W-1:0] VEC_T1  = 'h00C
) (
    input  logic             slot_valid,
    input  strobe_t          stb,
    input  logic             irq_ext,
    input  logic             irq_t0,
    input  logic             irq_t1,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  target,
    input  logic [PC_W-1:0]  stack_top,
    input  logic [LOW_W-1:0] pcl_data,
    output xfer_e            kind,
    output logic [PC_W-1:0]  next_pc
);
    localparam int PAGE_W = PC_W - LOW_W;

    logic [PAGE_W-1:0] page;
    assign page = cur_pc[PC_W-1:LOW_W];

    // Interrupt entry outranks the instruction; the instruction strobes
    // count only while the execute slot holds a real instruction.
    always_comb begin
        kind    = XF_NONE;
        next_pc = cur_pc + PC_W'(1);
        if (irq_ext) begin
            kind    = XF_IRQ;
            next_pc = VEC_EXT;
        end else if (irq_t0) begin
            kind    = XF_IRQ;
            next_pc = VEC_T0;
        end else if (irq_t1) begin
            kind    = XF_IRQ;
            next_pc = VEC_T1;
        end else if (slot_valid) begin
            if (stb.ret) begin
                kind    = XF_RET;
                next_pc = stack_top;
            end else if (stb.call) begin
                kind    = XF_CALL;
                next_pc = target;
            end else if (stb.jump) begin
                kind    = XF_JUMP;
                next_pc = target;
            end else if (stb.pcl) begin
                kind    = XF_PCL;
                next_pc = {page, pcl_data};
            end else if (stb.skip) begin
                kind    = XF_SKIP;
                next_pc = cur_pc + PC_W'(1);
            end
        end
    end

endmodule

// File: rtl/pcseq_fsm.sv
module pcseq_fsm
    import pcseq_pkg::*;
#(
    parameter int              PC_W    = 12,
    parameter logic [PC_W-1:0] VEC_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary,
    input  xfer_e           kind,
    input  logic [PC_W-1:0] next_pc,
    output logic            slot_valid,
    output logic            flush,
    output logic [PC_W-1:0] fetch_addr,
    output logic [PC_W-1:0] exec_pc,
    output logic            push,
    output logic [PC_W-1:0] push_addr,
    output logic            pop
);
    slot_e state, state_nx;
    logic  redirect;

    assign redirect = (kind != XF_NONE);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: advance (no transfer) or redirect (any transfer).
    always_comb begin
        state_nx = state;
        if (boundary) begin
            unique case (state)
                ST_FILL:  state_nx = redirect ? ST_DUMMY : ST_RUN;
                ST_RUN:   state_nx = redirect ? ST_DUMMY : ST_RUN;
                ST_DUMMY: state_nx = redirect ? ST_DUMMY : ST_RUN;
                default:  state_nx = ST_FILL;
            endcase
        end
    end

    assign slot_valid = (state == ST_RUN);
    assign flush      = !slot_valid;

    // Outputs and address registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_addr <= VEC_RST;
            exec_pc    <= VEC_RST;
            push       <= 1'b0;
            push_addr  <= '0;
            pop        <= 1'b0;
        end else begin
            push <= 1'b0;
            pop  <= 1'b0;
            if (boundary) begin
                fetch_addr <= next_pc;
                exec_pc    <= fetch_addr;
                if (kind == XF_CALL || kind == XF_IRQ) begin
                    push      <= 1'b1;
                    push_addr <= fetch_addr;
                end
                if (kind == XF_RET) begin
                    pop <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int              PC_W    = 12,
    parameter int              LOW_W   = 8,
    parameter int              PH_N    = 4,
    parameter logic [PC_W-1:0] VEC_RST = 'h000,
    parameter logic [PC_W-1:0] VEC_EXT = 'h004,
    parameter logic [PC_W-1:0] VEC_T0  = 'h008,
    parameter logic [PC_W-1:0] VEC_T1  = 'h00C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_ext,
    input  logic             irq_tmr0,
    input  logic             irq_tmr1,
    input  logic             do_skip,
    input  logic             do_pcl_wr,
    input  logic             do_jump,
    input  logic             do_call,
    input  logic             do_ret,
    input  logic [PC_W-1:0]  target,
    input  logic [PC_W-1:0]  stack_top,
    input  logic [LOW_W-1:0] pcl_data,
    output logic [PC_W-1:0]  fetch_addr,
    output logic [PC_W-1:0]  exec_pc,
    output logic             flush,
    output logic [PH_N-1:0]  phase,
    output logic             push,
    output logic [PC_W-1:0]  push_addr,
    output logic             pop
);
    logic            boundary;
    logic            slot_valid;
    xfer_e           kind;
    logic [PC_W-1:0] next_pc;
    strobe_t         stb;

    assign stb = '{ret: do_ret, call: do_call, jump: do_jump,
                   pcl: do_pcl_wr, skip: do_skip};

    pcseq_phase #(.PH_N(PH_N)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .boundary (boundary)
    );

    pcseq_arbiter #(
        .PC_W    (PC_W),
        .LOW_W   (LOW_W),
        .VEC_EXT (VEC_EXT),
        .VEC_T0  (VEC_T0),
        .VEC_T1  (VEC_T1)
    ) u_arb (
        .slot_valid (slot_valid),
        .stb        (stb),
        .irq_ext    (irq_ext),
        .irq_t0     (irq_tmr0),
        .irq_t1     (irq_tmr1),
        .cur_pc     (fetch_addr),
        .target     (target),
        .stack_top  (stack_top),
        .pcl_data   (pcl_data),
        .kind       (kind),
        .next_pc    (next_pc)
    );

    pcseq_fsm #(
        .PC_W    (PC_W),
        .VEC_RST (VEC_RST)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .kind       (kind),
        .next_pc    (next_pc),
        .slot_valid (slot_valid),
        .flush      (flush),
        .fetch_addr (fetch_addr),
        .exec_pc    (exec_pc),
        .push       (push),
        .push_addr  (push_addr),
        .pop        (pop)
    );

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
    parameter int              PC_W    = 12,
    parameter int              LOW_W   = 8,
    parameter int              PH_N    = 4,
    parameter logic [PC_W-1:0] VEC_EXT = 'h004
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_ext,
    input logic             irq_tmr0,
    input logic             irq_tmr1,
    input logic             do_skip,
    input logic             do_pcl_wr,
    input logic             do_jump,
    input logic             do_call,
    input logic             do_ret,
    input logic [PC_W-1:0]  target,
    input logic [PC_W-1:0]  stack_top,
    input logic [LOW_W-1:0] pcl_data,
    input logic [PC_W-1:0]  fetch_addr,
    input logic [PC_W-1:0]  exec_pc,
    input logic             flush,
    input logic [PH_N-1:0]  phase,
    input logic             push,
    input logic [PC_W-1:0]  push_addr,
    input logic             pop
);
    logic last_ph, irq_any, stb_any, live;
    assign last_ph = phase[PH_N-1];
    assign irq_any = irq_ext | irq_tmr0 | irq_tmr1;
    assign stb_any = do_skip | do_pcl_wr | do_jump | do_call | do_ret;
    assign live    = last_ph && !irq_any && !flush;

    assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);

    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        last_ph |=> phase[0]);

    assert_fetch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !last_ph |=> $stable(fetch_addr));

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_ph && !irq_any && (flush || !stb_any))
        |=> fetch_addr == PC_W'($past(fetch_addr) + 1'b1));

    assert_exec_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        last_ph |=> exec_pc == $past(fetch_addr));

    assert_jump_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && do_jump && !do_call && !do_ret)
        |=> (fetch_addr == $past(target)) && flush);

    assert_push_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> phase[0] && (push_addr == exec_pc));

    assert_ret_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && do_ret) |=> pop && (fetch_addr == $past(stack_top)));

    assert_pcl_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live && do_pcl_wr && !do_jump && !do_call && !do_ret)
        |=> (fetch_addr[PC_W-1:LOW_W] == $past(fetch_addr[PC_W-1:LOW_W]))
            && (fetch_addr[LOW_W-1:0] == $past(pcl_data)));

    assert_dummy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_ph && flush && !irq_any) |=> !flush && !push && !pop);

    assert_vec_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (last_ph && irq_ext) |=> (fetch_addr == VEC_EXT) && flush && push);

endmodule

bind pc_sequencer pcseq_checker #(
    .PC_W    (PC_W),
    .LOW_W   (LOW_W),
    .PH_N    (PH_N),
    .VEC_EXT (VEC_EXT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_ext    (irq_ext),
    .irq_tmr0   (irq_tmr0),
    .irq_tmr1   (irq_tmr1),
    .do_skip    (do_skip),
    .do_pcl_wr  (do_pcl_wr),
    .do_jump    (do_jump),
    .do_call    (do_call),
    .do_ret     (do_ret),
    .target     (target),
    .stack_top  (stack_top),
    .pcl_data   (pcl_data),
    .fetch_addr (fetch_addr),
    .exec_pc    (exec_pc),
    .flush      (flush),
    .phase      (phase),
    .push       (push),
    .push_addr  (push_addr),
    .pop        (pop)
);

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_ext = 1'b0, irq_tmr0 = 1'b0, irq_tmr1 = 1'b0;
    logic        do_skip = 1'b0, do_pcl_wr = 1'b0, do_jump = 1'b0;
    logic        do_call = 1'b0, do_ret = 1'b0;
    logic [11:0] target = '0, stack_top = '0;
    logic [7:0]  pcl_data = '0;
    logic [11:0] fetch_addr, exec_pc, push_addr;
    logic        flush, push, pop;
    logic [3:0]  phase;

    int total = 0;
    int bad   = 0;

    // Reference state, built from the requirements.
    logic [11:0] m_pc   = '0;
    logic [11:0] m_exec = '0;
    logic        m_flush = 1'b1;
    string       m_tag  = "R2 first fetch";

    always #5 clk = ~clk;

    pc_sequencer u0 (
        .clk(clk), .rst_n(rst_n),
        .irq_ext(irq_ext), .irq_tmr0(irq_tmr0), .irq_tmr1(irq_tmr1),
        .do_skip(do_skip), .do_pcl_wr(do_pcl_wr), .do_jump(do_jump),
        .do_call(do_call), .do_ret(do_ret),
        .target(target), .stack_top(stack_top), .pcl_data(pcl_data),
        .fetch_addr(fetch_addr), .exec_pc(exec_pc), .flush(flush),
        .phase(phase), .push(push), .push_addr(push_addr), .pop(pop)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One instruction cycle. Entered and left at the phase0 negedge.
    // s = {ret, call, jump, pcl, skip}; irq = {tmr1, tmr0, ext}.
    // glitch: the requests are shown only inside phases 1..3.
    task automatic cyc(input logic [4:0] s, input logic [11:0] a,
                       input logic [2:0] irq, input bit glitch);
        logic [11:0] npc;
        logic        nfl, xp, xo;
        logic [11:0] xpa;
        string       ntag;
        logic [2:0]  eirq;
        chk(m_tag, 32'(fetch_addr), 32'(m_pc));
        chk("R3 exec_pc follows fetch", 32'(exec_pc), 32'(m_exec));
        chk("R9 flush level", 32'(flush), 32'(m_flush));
        {do_ret, do_call, do_jump, do_pcl_wr, do_skip} = s;
        target = a; stack_top = a; pcl_data = a[7:0];
        eirq = glitch ? 3'b000 : irq;
        {irq_tmr1, irq_tmr0, irq_ext} = eirq;
        xp = 1'b0; xo = 1'b0; xpa = '0; nfl = 1'b1;
        npc = m_pc + 12'd1; ntag = "R3 sequential step";
        if (eirq[0]) begin npc = 12'h004; xp = 1'b1; xpa = m_pc; ntag = "R10 ext vector"; end
        else if (eirq[1]) begin npc = 12'h008; xp = 1'b1; xpa = m_pc; ntag = "R10 tmr0 vector"; end
        else if (eirq[2]) begin npc = 12'h00C; xp = 1'b1; xpa = m_pc; ntag = "R10 tmr1 vector"; end
        else if (!m_flush && s[4]) begin npc = a; xo = 1'b1; ntag = "R6 return target"; end
        else if (!m_flush && s[3]) begin npc = a; xp = 1'b1; xpa = m_pc; ntag = "R5 call target"; end
        else if (!m_flush && s[2]) begin npc = a; ntag = "R4 jump target"; end
        else if (!m_flush && s[1]) begin npc = {m_pc[11:8], a[7:0]}; ntag = "R7 page write"; end
        else if (!m_flush && s[0]) begin npc = m_pc + 12'd1; ntag = "R8 skip target"; end
        else begin
            nfl = 1'b0;
            if (m_flush && s != 5'd0) ntag = "R9 strobes ignored in dummy slot";
            if (s != 5'd0 && !m_flush && $countones(s) > 1) ntag = "R12 strobe precedence";
        end
        if (!m_flush && $countones(s) > 1 && eirq == 3'b000) ntag = {ntag, " R12"};
        if (glitch) ntag = {ntag, " R11 glitch ignored"};
        for (int i = 0; i < 4; i++) begin
            chk("R1 phase one-hot order", 32'(phase), 32'(4'b0001 << i));
            chk("R1 fetch held in cycle", 32'(fetch_addr), 32'(m_pc));
            if (glitch && i == 1) {irq_tmr1, irq_tmr0, irq_ext} = irq;
            if (glitch && i == 3) {irq_tmr1, irq_tmr0, irq_ext} = 3'b000;
            @(negedge clk);
        end
        {do_ret, do_call, do_jump, do_pcl_wr, do_skip} = 5'd0;
        {irq_tmr1, irq_tmr0, irq_ext} = 3'b000;
        chk("R5 push strobe", 32'(push), 32'(xp));
        if (xp) chk("R5 push address", 32'(push_addr), 32'(xpa));
        chk("R6 pop strobe", 32'(pop), 32'(xo));
        m_exec = m_pc; m_pc = npc; m_flush = nfl; m_tag = ntag;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 reset fetch", 32'(fetch_addr), 32'h000);
        chk("R2 reset exec", 32'(exec_pc), 32'h000);
        chk("R2 reset phase", 32'(phase), 32'h1);
        chk("R2 reset flush", 32'(flush), 32'h1);
        chk("R2 reset push/pop", 32'({push, pop}), 32'h0);
        rst_n = 1'b1;
        // R2 first cycle is an empty slot, then R3 straight-line code
        for (int k = 0; k < 8; k++) cyc(5'd0, 12'h000, 3'b000, 1'b0);
        // R4 jump sweep over the whole address space
        for (int t = 0; t < 256; t++) begin
            cyc(5'b00100, 12'((t << 4) | (t & 15)), 3'b000, 1'b0);
            cyc(5'd0, 12'h000, 3'b000, 1'b0);
        end
        // R7 low-byte write, every data value, in varying pages
        for (int d = 0; d < 256; d++) begin
            cyc(5'b00100, 12'((d & 15) << 8), 3'b000, 1'b0);
            cyc(5'd0, 12'h000, 3'b000, 1'b0);
            cyc(5'b00010, 12'(d), 3'b000, 1'b0);
        end
        // R5 / R6 call and return pairs
        for (int i = 0; i < 32; i++) begin
            cyc(5'b01000, 12'(i * 128 + 5), 3'b000, 1'b0);
            cyc(5'd0, 12'h000, 3'b000, 1'b0);
            cyc(5'b10000, 12'(i * 7 + 300), 3'b000, 1'b0);
            cyc(5'd0, 12'h000, 3'b000, 1'b0);
        end
        // R8 skips
        for (int i = 0; i < 16; i++) begin
            cyc(5'b00001, 12'h000, 3'b000, 1'b0);
            cyc(5'd0, 12'h000, 3'b000, 1'b0);
        end
        // R9 back-to-back transfers: the second lands in the dummy slot
        for (int i = 0; i < 8; i++) begin
            cyc(5'b00100, 12'(i * 300 + 17), 3'b000, 1'b0);
            cyc(5'b11111, 12'h5A5, 3'b000, 1'b0);
            cyc(5'd0, 12'h000, 3'b000, 1'b0);
        end
        // R12 every strobe combination, each from a valid slot
        for (int s = 1; s < 32; s++) begin
            cyc(5'(s), 12'(s * 97 + 33), 3'b000, 1'b0);
            cyc(5'd0, 12'h000, 3'b000, 1'b0);
        end
        // R10 every request combination, with and without a transfer
        for (int v = 1; v < 8; v++) begin
            cyc(5'd0, 12'h000, 3'(v), 1'b0);
            cyc(5'd0, 12'h000, 3'b000, 1'b0);
            cyc(5'b01100, 12'h3C3, 3'(v), 1'b0);
            cyc(5'd0, 12'h000, 3'(v), 1'b0);
            cyc(5'd0, 12'h000, 3'b000, 1'b0);
        end
        // R11 requests confined inside the cycle
        for (int v = 1; v < 8; v++) begin
            cyc(5'd0, 12'h000, 3'(v), 1'b1);
        end
        // R3 wrap from 0xFFF to 0x000
        cyc(5'b00100, 12'hFFE, 3'b000, 1'b0);
        for (int k = 0; k < 4; k++) cyc(5'd0, 12'h000, 3'b000, 1'b0);
        // R2 reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 reset again fetch", 32'(fetch_addr), 32'h000);
        chk("R2 reset again flush", 32'(flush), 32'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule